// File: doc/BRIEF.md
# Shadowed Real-Time Clock with Alarms

This block keeps wall-clock time for a chip: a prescaler turns a slow timebase pulse into milliseconds, and milliseconds carry into a 32-bit seconds counter that wraps to zero. The counters live on the timebase side. The values software reads are copies, refreshed once per copy window of a fixed number of timebase ticks. A busy flag reads 1 for the last tick period of each window, which is when the copy is taken. Software should write time, alarm or mask registers only while that flag is clear.

A read of the millisecond register also latches the copied seconds into a held-seconds register. Software can therefore read milliseconds first and then held seconds, and get a pair taken at the same moment. Two seconds alarms and one millisecond alarm compare against the counters as they advance. Each alarm sets a sticky flag bit, which software clears by writing 1 to it. A level-high interrupt line is asserted while any flag bit is set and its enable bit is also set.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_o` is low.
- R2: The register at 0x0C reads 1 in bit 0 during the last tick period of every `COPY_TICKS` ticks, counted from reset. On the tick that ends that period, the seconds (0x00) and milliseconds (0x04) registers take the counter values held just before that tick. Between copies they do not change.
- R3: Every `TICKS_PER_MS` ticks the millisecond counter advances. It counts 0 to `MS_PER_SEC`-1, and its wrap to 0 adds one to the seconds counter.
- R4: An accepted write to 0x00 loads the seconds counter, and sets the millisecond counter and the prescaler to zero.
- R5: While busy reads 1, writes to 0x00, to the alarm registers (0x10, 0x14, 0x18) and to the enable register (0x1C) have no effect.
- R6: A read of 0x04 copies the current value of register 0x00 into held seconds (0x08). Reads of other addresses leave 0x08 unchanged.
- R7: Seconds alarm 0 (0x10) sets flag bit 0, and seconds alarm 1 (0x14) sets flag bit 1. A flag sets on the tick where the seconds counter advances to a value equal to that alarm. An alarm value of 0 never sets its flag, including when the counter wraps to 0.
- R8: The millisecond alarm (0x18) sets flag bit 2 on the tick where the millisecond counter advances to a value equal to the alarm.
- R9: The seconds counter wraps from 0xFFFFFFFF to 0.
- R10: Flag register 0x20 is sticky. Writing 1 to a bit clears it, and writing 0 has no effect. Flags set whether or not they are enabled. Bits 3 and 4, the countdown flags, are never set by this block.
- R11: `irq_o` is high exactly when some bit is set both in the flags (0x20) and in the enables (0x1C, bits 0 to 4).
- R12: A read of any address outside the map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per slow timebase period |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (its side effect applies at the clock edge) |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with `TICKS_PER_MS` = 2 and `MS_PER_SEC` = 10, and keeps `COPY_TICKS` at 8. With these values a second passes every 20 ticks. That makes it practical to reach, in a short run, seconds carries, alarm matches, the wrap from 0xFFFFFFFF to 0, and a millisecond alarm firing partway through a second. Because a copy window of 8 ticks is not a multiple of the 20-tick second, copies land at varying millisecond phases. This exercises the coherence between milliseconds and held seconds.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int ADDR_W      = 8;
  localparam int IRQ_W       = 5;
  localparam int NUM_SEC_ALM = 2;
  localparam int BIT_MS_ALM  = 2;

  localparam logic [ADDR_W-1:0] A_SEC    = 8'h00;
  localparam logic [ADDR_W-1:0] A_MS     = 8'h04;
  localparam logic [ADDR_W-1:0] A_HELD   = 8'h08;
  localparam logic [ADDR_W-1:0] A_BUSY   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_ALM_S0 = 8'h10;
  localparam logic [ADDR_W-1:0] A_ALM_S1 = 8'h14;
  localparam logic [ADDR_W-1:0] A_ALM_MS = 8'h18;
  localparam logic [ADDR_W-1:0] A_IRQ_EN = 8'h1C;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 8'h20;
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int TICKS_PER_MS = 32,
  parameter int MS_PER_SEC   = 1000,
  parameter int SEC_W        = 32,
  localparam int MS_W        = $clog2(MS_PER_SEC),
  localparam int PRE_W       = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [MS_W-1:0]  ms_o,
  output logic             ms_step_o,
  output logic             sec_step_o,
  output logic [MS_W-1:0]  ms_nxt_o,
  output logic [SEC_W-1:0] sec_nxt_o
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             pre_wrap, ms_wrap;

  always_comb begin
    pre_wrap   = (pre_q == PRE_W'(TICKS_PER_MS - 1));
    ms_wrap    = (ms_q == MS_W'(MS_PER_SEC - 1));
    ms_step_o  = tick_i & pre_wrap & ~load_i;
    sec_step_o = ms_step_o & ms_wrap;
    ms_nxt_o   = ms_wrap ? '0 : ms_q + MS_W'(1);
    sec_nxt_o  = sec_q + SEC_W'(1);

    pre_d = pre_q;
    ms_d  = ms_q;
    sec_d = sec_q;
    if (load_i) begin
      sec_d = load_sec_i;
      ms_d  = '0;
      pre_d = '0;
    end else if (tick_i) begin
      pre_d = pre_wrap ? '0 : pre_q + PRE_W'(1);
      if (ms_step_o)  ms_d  = ms_nxt_o;
      if (sec_step_o) sec_d = sec_nxt_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
      sec_q <= sec_d;
    end
  end

  assign sec_o = sec_q;
  assign ms_o  = ms_q;

  p_ms_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q < MS_W'(MS_PER_SEC));

  p_load_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ms_q == '0) && (sec_q == $past(load_sec_i)));
endmodule

// File: rtl/rtc_bus_copy.sv
module rtc_bus_copy #(
  parameter int COPY_TICKS = 8,
  parameter int SEC_W      = 32,
  parameter int MS_W       = 10,
  localparam int PH_W      = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEC_W-1:0] core_sec_i,
  input  logic [MS_W-1:0]  core_ms_i,
  output logic             busy_o,
  output logic [SEC_W-1:0] bus_sec_o,
  output logic [MS_W-1:0]  bus_ms_o
);
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [SEC_W-1:0] bsec_q, bsec_d;
  logic [MS_W-1:0]  bms_q, bms_d;
  logic             last_ph, copy_en;

  always_comb begin
    last_ph = (phase_q == PH_W'(COPY_TICKS - 1));
    copy_en = tick_i & last_ph;
    phase_d = phase_q;
    if (tick_i) phase_d = last_ph ? '0 : phase_q + PH_W'(1);
    bsec_d = copy_en ? core_sec_i : bsec_q;
    bms_d  = copy_en ? core_ms_i  : bms_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bsec_q  <= '0;
      bms_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bsec_q  <= bsec_d;
      bms_q   <= bms_d;
    end
  end

  assign busy_o    = last_ph;
  assign bus_sec_o = bsec_q;
  assign bus_ms_o  = bms_q;

  p_copy_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bms_q) |-> $past(busy_o));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_shadow_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int MS_W  = 10
) (
  input  logic                               sec_step_i,
  input  logic [SEC_W-1:0]                   sec_nxt_i,
  input  logic                               ms_step_i,
  input  logic [MS_W-1:0]                    ms_nxt_i,
  input  logic [NUM_SEC_ALM-1:0][SEC_W-1:0]  alm_sec_i,
  input  logic [MS_W-1:0]                    alm_ms_i,
  output logic [IRQ_W-1:0]                   hit_o
);
  logic [NUM_SEC_ALM-1:0] sec_hit;

  for (genvar g = 0; g < NUM_SEC_ALM; g++) begin : g_sec_alm
    always_comb
      sec_hit[g] = sec_step_i && (alm_sec_i[g] != '0) && (sec_nxt_i == alm_sec_i[g]);
  end

  always_comb begin
    hit_o                       = '0;
    hit_o[NUM_SEC_ALM-1:0]      = sec_hit;
    hit_o[BIT_MS_ALM]           = ms_step_i && (ms_nxt_i == alm_ms_i);
  end
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl
  import rtc_shadow_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] hit_i,
  input  logic             en_we_i,
  input  logic [IRQ_W-1:0] en_wd_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] clr_wd_i,
  output logic [IRQ_W-1:0] flags_o,
  output logic [IRQ_W-1:0] en_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] flags_q, flags_d, en_q, en_d, clr_eff;

  always_comb begin
    clr_eff = clr_we_i ? clr_wd_i : '0;
    flags_d = (flags_q & ~clr_eff) | hit_i;
    en_d    = en_we_i ? en_wd_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_eff == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_cdn_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[4:3] == 2'b00);
endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock
  import rtc_shadow_pkg::*;
#(
  parameter int TICKS_PER_MS = 32,
  parameter int MS_PER_SEC   = 1000,
  parameter int COPY_TICKS   = 8,
  parameter int SEC_W        = 32,
  localparam int MS_W        = $clog2(MS_PER_SEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEC_W-1:0]  wdata_i,
  output logic [SEC_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [SEC_W-1:0] core_sec, sec_nxt, bus_sec;
  logic [MS_W-1:0]  core_ms, ms_nxt, bus_ms;
  logic             ms_step, sec_step, busy;
  logic             wr_ok, sec_load;
  logic [NUM_SEC_ALM-1:0][SEC_W-1:0] alm_sec_q, alm_sec_d;
  logic [MS_W-1:0]  alm_ms_q, alm_ms_d;
  logic [SEC_W-1:0] held_q, held_d;
  logic [IRQ_W-1:0] hit, flags, irq_en;

  rtc_time_core #(
    .TICKS_PER_MS(TICKS_PER_MS), .MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W)
  ) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .load_i(sec_load), .load_sec_i(wdata_i),
    .sec_o(core_sec), .ms_o(core_ms),
    .ms_step_o(ms_step), .sec_step_o(sec_step),
    .ms_nxt_o(ms_nxt), .sec_nxt_o(sec_nxt)
  );

  rtc_bus_copy #(
    .COPY_TICKS(COPY_TICKS), .SEC_W(SEC_W), .MS_W(MS_W)
  ) u_copy (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .core_sec_i(core_sec), .core_ms_i(core_ms),
    .busy_o(busy), .bus_sec_o(bus_sec), .bus_ms_o(bus_ms)
  );

  rtc_alarm_cmp #(.SEC_W(SEC_W), .MS_W(MS_W)) u_alarm (
    .sec_step_i(sec_step), .sec_nxt_i(sec_nxt),
    .ms_step_i(ms_step), .ms_nxt_i(ms_nxt),
    .alm_sec_i(alm_sec_q), .alm_ms_i(alm_ms_q),
    .hit_o(hit)
  );

  rtc_irq_ctl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit),
    .en_we_i(wr_ok && (addr_i == A_IRQ_EN)), .en_wd_i(wdata_i[IRQ_W-1:0]),
    .clr_we_i(wr_en_i && (addr_i == A_FLAGS)), .clr_wd_i(wdata_i[IRQ_W-1:0]),
    .flags_o(flags), .en_o(irq_en), .irq_o(irq_o)
  );

  always_comb begin
    wr_ok     = wr_en_i & ~busy;
    sec_load  = wr_ok && (addr_i == A_SEC);
    alm_sec_d = alm_sec_q;
    if (wr_ok && (addr_i == A_ALM_S0)) alm_sec_d[0] = wdata_i;
    if (wr_ok && (addr_i == A_ALM_S1)) alm_sec_d[1] = wdata_i;
    alm_ms_d  = (wr_ok && (addr_i == A_ALM_MS)) ? wdata_i[MS_W-1:0] : alm_ms_q;
    held_d    = (rd_en_i && (addr_i == A_MS)) ? bus_sec : held_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_sec_q <= '0;
      alm_ms_q  <= '0;
      held_q    <= '0;
    end else begin
      alm_sec_q <= alm_sec_d;
      alm_ms_q  <= alm_ms_d;
      held_q    <= held_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SEC:    rdata_o = bus_sec;
      A_MS:     rdata_o = SEC_W'(bus_ms);
      A_HELD:   rdata_o = held_q;
      A_BUSY:   rdata_o = SEC_W'(busy);
      A_ALM_S0: rdata_o = alm_sec_q[0];
      A_ALM_S1: rdata_o = alm_sec_q[1];
      A_ALM_MS: rdata_o = SEC_W'(alm_ms_q);
      A_IRQ_EN: rdata_o = SEC_W'(irq_en);
      A_FLAGS:  rdata_o = SEC_W'(flags);
      default:  rdata_o = '0;
    endcase
  end

  p_held_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == A_MS)) |=> (held_q == $past(bus_sec)));

  p_busy_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy && (addr_i == A_ALM_S0)) |=> $stable(alm_sec_q[0]));

  p_zero_alarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_sec_q[0] == '0) |-> !hit[0]);

  p_irq_level_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o);
endmodule

// File: tb/rtc_shadow_clock_bench.sv
module rtc_shadow_clock_bench;
  import rtc_shadow_pkg::*;

  localparam int TPM = 2;
  localparam int MPS = 10;
  localparam int CPT = 8;

  logic        clk, rst_n, tick, wr_en, rd_en, irq;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;

  int checks = 0;
  int errors = 0;

  // requirement-level model
  int unsigned m_pre, m_ms, m_phase, m_bms;
  logic [31:0] m_sec, m_bsec, m_held;
  logic [31:0] m_alm0, m_alm1;
  int unsigned m_alm_ms;
  logic [4:0]  m_flags, m_en;

  rtc_shadow_clock #(.TICKS_PER_MS(TPM), .MS_PER_SEC(MPS), .COPY_TICKS(CPT)) u_rtc_shadow_clock (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
    if (m_phase == CPT - 1) begin
      m_bsec = m_sec;
      m_bms  = m_ms;
    end
    m_phase = (m_phase + 1) % CPT;
    if (m_pre == TPM - 1) begin
      m_pre = 0;
      if (m_ms == MPS - 1) begin
        m_ms  = 0;
        m_sec = m_sec + 32'd1;
        if (m_alm0 != 0 && m_sec == m_alm0) m_flags[0] = 1'b1;
        if (m_alm1 != 0 && m_sec == m_alm1) m_flags[1] = 1'b1;
      end else begin
        m_ms = m_ms + 1;
      end
      if (m_ms == m_alm_ms) m_flags[2] = 1'b1;
    end else begin
      m_pre = m_pre + 1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic to_idle();
    while (m_phase == CPT - 1) do_tick();
  endtask

  task automatic to_copy();
    do_tick();
    while (m_phase != 0) do_tick();
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bit ok;
    ok = (m_phase != CPT - 1);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (a == A_FLAGS) m_flags = m_flags & ~d[4:0];
    else if (ok) begin
      case (a)
        A_SEC:    begin m_sec = d; m_ms = 0; m_pre = 0; end
        A_ALM_S0: m_alm0 = d;
        A_ALM_S1: m_alm1 = d;
        A_ALM_MS: m_alm_ms = d % 16;
        A_IRQ_EN: m_en = d[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #2 d = rdata;
    @(posedge clk);
    #1 rd_en = 1'b0;
    if (a == A_MS) m_held = m_bsec;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(req, {31'd0, irq}, {31'd0, (m_flags & m_en) != 5'd0});
  endtask

  task automatic t_reset();
    chk_irq("R1 irq after reset");
    chk_rd("R1 seconds", A_SEC, 0);
    chk_rd("R1 ms", A_MS, 0);
    chk_rd("R1 held", A_HELD, 0);
    chk_rd("R1 busy", A_BUSY, 0);
    chk_rd("R1 flags", A_FLAGS, 0);
    chk_rd("R1 enables", A_IRQ_EN, 0);
    chk_rd("R12 unmapped", 8'h3C, 0);
  endtask

  task automatic t_copy_window();
    ticks(CPT - 1);
    chk_rd("R2 busy in last period", A_BUSY, 1);
    chk_rd("R2 seconds before copy", A_SEC, m_bsec);
    chk_rd("R2 ms before copy", A_MS, 0);
    do_tick();
    chk_rd("R2 busy clear after copy", A_BUSY, 0);
    chk_rd("R3 ms copied", A_MS, 3);
  endtask

  task automatic t_load_seconds();
    to_idle();
    bus_wr(A_SEC, 32'd100);
    to_copy();
    chk_rd("R4 seconds loaded", A_SEC, m_bsec);
    chk_rd("R4 ms restarted", A_MS, m_bms);
    ticks(24);
    to_copy();
    chk_rd("R3 seconds carry", A_SEC, m_bsec);
    chk_rd("R3 ms count", A_MS, m_bms);
  endtask

  task automatic t_busy_writes();
    while (m_phase != CPT - 1) do_tick();
    bus_wr(A_SEC, 32'd555);
    bus_wr(A_ALM_S0, 32'd7);
    bus_wr(A_IRQ_EN, 32'h1F);
    do_tick();
    chk_rd("R5 enable write dropped", A_IRQ_EN, 0);
    chk_rd("R5 alarm write dropped", A_ALM_S0, 0);
    to_copy();
    chk_rd("R5 seconds write dropped", A_SEC, m_bsec);
  endtask

  task automatic t_held();
    logic [31:0] d;
    bus_rd(A_MS, d);
    chk_rd("R6 held after ms read", A_HELD, m_held);
    ticks(2 * CPT);
    bus_rd(A_SEC, d);
    chk("R6 seconds moved", d, m_bsec);
    chk_rd("R6 held unchanged by other reads", A_HELD, m_held);
    bus_rd(A_MS, d);
    chk_rd("R6 held recaptured", A_HELD, m_bsec);
  endtask

  task automatic t_alarm0();
    to_idle(); bus_wr(A_IRQ_EN, 32'h1);
    to_idle(); bus_wr(A_SEC, 32'd200);
    to_idle(); bus_wr(A_ALM_S0, 32'd201);
    ticks(TPM * MPS);
    chk_rd("R7 alarm0 flag", A_FLAGS, {27'd0, m_flags});
    chk("R7 alarm0 bit model", {31'd0, m_flags[0]}, 1);
    chk_irq("R11 irq on enabled flag");
  endtask

  task automatic t_clear();
    bus_wr(A_FLAGS, 32'h0);
    chk_rd("R10 write zero keeps flags", A_FLAGS, {27'd0, m_flags});
    bus_wr(A_FLAGS, 32'h1);
    chk_rd("R10 write one clears bit", A_FLAGS, {27'd0, m_flags});
    chk_irq("R11 irq after clear");
  endtask

  task automatic t_alarm1_masked();
    to_idle(); bus_wr(A_IRQ_EN, 32'h0);
    bus_wr(A_FLAGS, 32'h1F);
    to_idle(); bus_wr(A_SEC, 32'd300);
    to_idle(); bus_wr(A_ALM_S1, 32'd301);
    ticks(TPM * MPS);
    chk_rd("R10 flag sets while disabled", A_FLAGS, {27'd0, m_flags});
    chk("R7 alarm1 bit model", {31'd0, m_flags[1]}, 1);
    chk_irq("R11 irq low when disabled");
    to_idle(); bus_wr(A_IRQ_EN, 32'h2);
    chk_irq("R11 irq high once enabled");
  endtask

  task automatic t_ms_alarm();
    to_idle(); bus_wr(A_IRQ_EN, 32'h0);
    to_idle(); bus_wr(A_ALM_MS, 32'd5);
    to_idle(); bus_wr(A_SEC, 32'd400);
    bus_wr(A_FLAGS, 32'h1F);
    ticks(TPM * 5 - 1);
    chk_rd("R8 ms alarm not yet", A_FLAGS, {27'd0, m_flags});
    do_tick();
    chk_rd("R8 ms alarm flag", A_FLAGS, {27'd0, m_flags});
    chk("R8 ms alarm bit model", {31'd0, m_flags[2]}, 1);
  endtask

  task automatic t_wrap_zero();
    to_idle(); bus_wr(A_ALM_S0, 32'd0);
    to_idle(); bus_wr(A_ALM_S1, 32'd0);
    to_idle(); bus_wr(A_ALM_MS, 32'd15);
    to_idle(); bus_wr(A_SEC, 32'hFFFF_FFFF);
    bus_wr(A_FLAGS, 32'h1F);
    ticks(TPM * MPS);
    to_copy();
    chk_rd("R9 seconds wrapped", A_SEC, m_bsec);
    chk("R9 wrap model", m_sec, 32'd0);
    chk_rd("R7 zero alarm silent at wrap", A_FLAGS, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    m_pre = 0; m_ms = 0; m_phase = 0; m_bms = 0;
    m_sec = '0; m_bsec = '0; m_held = '0;
    m_alm0 = '0; m_alm1 = '0; m_alm_ms = 0; m_flags = '0; m_en = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_copy_window();
    t_load_seconds();
    t_busy_writes();
    t_held();
    t_alarm0();
    t_clear();
    t_alarm1_masked();
    t_ms_alarm();
    t_wrap_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule